// File: doc/BRIEF.md
# Gated Divide-by-Eight Sample Source

This block generates the excitation stream for a downstream sampled-data filter. An internal square-wave oscillator is built as a clock-enable on the system clock: a counter of `HALF_PERIOD` system cycles sets each half of its period. The oscillator does not run while `enable` is low. Each rising edge of the oscillator makes a one-cycle `sample_valid` pulse, and the downstream filter advances only on that pulse.

Three divide-by-two stages follow the oscillator. Each one behaves as a flip-flop whose inverted output feeds its own data input and which is clocked by the stage below it. Here the chain is synchronous: on an oscillator rising edge, a stage toggles when every stage beneath it is 0. The chain therefore counts down modulo eight, and its top bit is a square wave at one eighth of the oscillator frequency. On each pulse the top bit, as it was just before the edge, is recoded into a signed Q2.14 sample of -1 or +1.

Top module: `gated_div8_source`

## Requirements
- R1: While `enable` is low, `sample_valid` stays 0 and `div_out` does not change.
- R2: After reset, the first `sample_valid` pulse appears exactly `HALF_PERIOD` cycles after the cycle in which `enable` is set high.
- R3: While `enable` stays high, consecutive `sample_valid` pulses are exactly `2*HALF_PERIOD` cycles apart.
- R4: `div_out` changes only in a cycle where `sample_valid` is 1. It holds its level for four pulses and then inverts, so its frequency is one eighth of the oscillator frequency.
- R5: `sample` is always either 16'shC000 (-1.0 in Q2.14, for a 0 bit) or 16'sh4000 (+1.0, for a 1 bit). On each pulse it carries the value `div_out` had in the cycle before that pulse.
- R6: Reset sets `sample_valid` to 0, `div_out` to 0 and `sample` to 16'shC000.
- R7: From reset, the sample sequence is -1, then four +1, then four -1, and the pattern of eight repeats.
- R8: Taking `enable` low and then high again, either right after a pulse or partway through a period, neither drops nor inserts any sample in the R7 sequence.
- R9: `sample_valid` is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Lets the oscillator run when high |
| sample_valid | output | 1 | One-cycle pulse on each oscillator rising edge |
| div_out | output | 1 | Oscillator divided by eight |
| sample | output | SAMPLE_W | Signed Q2.14 sample, -1 or +1 |

## Verification
The hardest case to reach from the ports is a pause that lands partway through an oscillator half-period. In that case the half-period counter restarts while the phase is kept, so the timing of the next pulse changes but the sample sequence must not. The stimulus first drops `enable` just after a pulse and then again a few cycles into a later period. The scoreboard expects the same uninterrupted run of samples. Spacing checks are suspended only across the pulse that follows each pause.

// File: rtl/gdiv_pkg.sv
package gdiv_pkg;

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } osc_phase_e;

    function automatic logic signed [31:0] unit_level(input logic bit_in, input int frac_bits);
        logic signed [31:0] mag;
        mag = 32'sd1 <<< frac_bits;
        return bit_in ? mag : -mag;
    endfunction

endpackage

// File: rtl/osc_tick_gen.sv
module osc_tick_gen
    import gdiv_pkg::*;
#(
    parameter int HALF_PERIOD = 4,
    parameter int CNT_W       = (HALF_PERIOD > 1) ? $clog2(HALF_PERIOD) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    output logic rise_tick
);

    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(HALF_PERIOD - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        osc_phase_e       phase;
    } osc_state_t;

    osc_state_t st_d, st_q;
    logic       rise_d;

    always_comb begin
        st_d   = st_q;
        rise_d = 1'b0;
        if (!enable) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == LAST_CNT) begin
            st_d.cnt   = '0;
            st_d.phase = (st_q.phase == PH_LOW) ? PH_HIGH : PH_LOW;
            rise_d     = (st_q.phase == PH_LOW);
        end else begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cnt: '0, phase: PH_LOW};
        end else begin
            st_q <= st_d;
        end
    end

    assign rise_tick = rise_d;

endmodule

// File: rtl/toggle_chain.sv
module toggle_chain #(
    parameter int STAGES = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance,
    output logic [STAGES-1:0] stages
);

    logic [STAGES:0]   borrow;
    logic [STAGES-1:0] stg_d, stg_q;

    assign borrow[0] = advance;

    generate
        for (genvar k = 0; k < STAGES; k++) begin : g_stage
            assign borrow[k+1] = borrow[k] & ~stg_q[k];
        end
    endgenerate

    always_comb begin
        stg_d = stg_q ^ borrow[STAGES-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_q <= '0;
        end else begin
            stg_q <= stg_d;
        end
    end

    assign stages = stg_q;

endmodule

// File: rtl/sample_mapper.sv
module sample_mapper
    import gdiv_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int FRAC_W   = 14
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load,
    input  logic                       level_bit,
    output logic                       valid,
    output logic signed [SAMPLE_W-1:0] sample
);

    localparam logic signed [SAMPLE_W-1:0] NEG_ONE = SAMPLE_W'(unit_level(1'b0, FRAC_W));

    typedef struct packed {
        logic                       vld;
        logic signed [SAMPLE_W-1:0] smp;
    } map_state_t;

    map_state_t ms_d, ms_q;

    always_comb begin
        ms_d     = ms_q;
        ms_d.vld = load;
        if (load) begin
            ms_d.smp = SAMPLE_W'(unit_level(level_bit, FRAC_W));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ms_q <= '{vld: 1'b0, smp: NEG_ONE};
        end else begin
            ms_q <= ms_d;
        end
    end

    assign valid  = ms_q.vld;
    assign sample = ms_q.smp;

endmodule

// File: rtl/gated_div8_source.sv
module gated_div8_source #(
    parameter int HALF_PERIOD = 4,
    parameter int DIV_STAGES  = 3,
    parameter int SAMPLE_W    = 16,
    parameter int FRAC_W      = 14
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       enable,
    output logic                       sample_valid,
    output logic                       div_out,
    output logic signed [SAMPLE_W-1:0] sample
);

    localparam int TOP_STAGE = DIV_STAGES - 1;

    logic                  osc_rise;
    logic [DIV_STAGES-1:0] div_bits;

    osc_tick_gen #(
        .HALF_PERIOD (HALF_PERIOD)
    ) u_osc (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .rise_tick (osc_rise)
    );

    toggle_chain #(
        .STAGES (DIV_STAGES)
    ) u_chain (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (osc_rise),
        .stages  (div_bits)
    );

    sample_mapper #(
        .SAMPLE_W (SAMPLE_W),
        .FRAC_W   (FRAC_W)
    ) u_map (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (osc_rise),
        .level_bit (div_bits[TOP_STAGE]),
        .valid     (sample_valid),
        .sample    (sample)
    );

    assign div_out = div_bits[TOP_STAGE];

endmodule

// File: rtl/gated_div8_source_chk.sv
module gated_div8_source_chk #(
    parameter int SAMPLE_W = 16,
    parameter int FRAC_W   = 14
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       enable,
    input logic                       sample_valid,
    input logic                       div_out,
    input logic signed [SAMPLE_W-1:0] sample
);

    localparam logic signed [SAMPLE_W-1:0] POS_ONE = SAMPLE_W'(1 << FRAC_W);
    localparam logic signed [SAMPLE_W-1:0] NEG_ONE = -POS_ONE;

    p_no_valid_when_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !sample_valid);

    p_div_frozen_when_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> $stable(div_out));

    p_div_moves_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(div_out) |-> sample_valid);

    p_level_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sample == POS_ONE) || (sample == NEG_ONE));

    p_reset_state_r6: assert property (@(posedge clk)
        !rst_n |=> (!sample_valid && !div_out && sample == NEG_ONE));

    p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |=> !sample_valid);

endmodule

bind gated_div8_source gated_div8_source_chk #(
    .SAMPLE_W (SAMPLE_W),
    .FRAC_W   (FRAC_W)
) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (enable),
    .sample_valid (sample_valid),
    .div_out      (div_out),
    .sample       (sample)
);

// File: tb/test_gated_div8_source.sv
module test_gated_div8_source;

    localparam int HALF = 4;
    localparam logic signed [15:0] POS = 16'sh4000;
    localparam logic signed [15:0] NEG = 16'shC000;

    typedef struct {
        logic signed [15:0] smp;
        logic               div;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic sample_valid;
    logic div_out;
    logic signed [15:0] sample;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int valid_cnt = 0;
    int last_valid_cyc = -100;
    int first_valid_cyc = -1;
    bit spacing_armed = 1'b0;
    bit done = 1'b0;
    logic [2:0] model_cnt = 3'd0;
    exp_t exp_q[$];

    gated_div8_source #(.HALF_PERIOD(HALF)) i_gated_div8_source (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (enable),
        .sample_valid (sample_valid),
        .div_out      (div_out),
        .sample       (sample)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Driver: each tick, the sample is the top bit before the down-count step
    task automatic push_expected(input int n);
        for (int i = 0; i < n; i++) begin
            exp_t e;
            e.smp = model_cnt[2] ? POS : NEG;
            model_cnt = model_cnt - 3'd1;
            e.div = model_cnt[2];
            exp_q.push_back(e);
        end
    endtask

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic drain_queue();
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    task automatic set_enable(input logic v);
        @(negedge clk);
        #1 enable = v;
    endtask

    task automatic pause_and_check(input int n);
        int v0;
        logic d0;
        set_enable(1'b0);
        v0 = valid_cnt;
        d0 = div_out;
        spacing_armed = 1'b0;
        wait_cycles(n);
        check(valid_cnt == v0, "R1 no pulse while disabled", valid_cnt - v0, 0);
        check(div_out == d0, "R1 div_out held while disabled", int'(div_out), int'(d0));
    endtask

    // Monitor: pop and compare on each pulse
    always @(negedge clk) begin
        if (rst_n && sample_valid) begin
            valid_cnt++;
            if (first_valid_cyc < 0) first_valid_cyc = cyc;
            check(last_valid_cyc != cyc - 1, "R9 pulse one cycle wide", cyc - last_valid_cyc, 2 * HALF);
            if (spacing_armed)
                check(cyc - last_valid_cyc == 2 * HALF, "R3 pulse spacing", cyc - last_valid_cyc, 2 * HALF);
            last_valid_cyc = cyc;
            spacing_armed = 1'b1;
            if (exp_q.size() == 0) begin
                check(1'b0, "R1/R8 unexpected extra sample", int'(sample), 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(sample == e.smp, "R5/R7/R8 sample value", int'(sample), int'(e.smp));
                check(div_out == e.div, "R4 div_out level", int'(div_out), int'(e.div));
            end
        end
    end

    initial begin
        int en_cyc;
        wait_cycles(3);
        check(sample_valid == 1'b0, "R6 reset valid", int'(sample_valid), 0);
        check(div_out == 1'b0, "R6 reset div_out", int'(div_out), 0);
        check(sample == NEG, "R6 reset sample", int'(sample), int'(NEG));
        #1 rst_n = 1'b1;

        // Held off: nothing moves
        wait_cycles(20);
        check(valid_cnt == 0, "R1 no pulse before enable", valid_cnt, 0);
        check(div_out == 1'b0, "R1 div_out idle before enable", int'(div_out), 0);

        push_expected(20);
        @(negedge clk);
        en_cyc = cyc;
        #1 enable = 1'b1;
        drain_queue();
        check(first_valid_cyc - en_cyc == HALF, "R2 first pulse latency", first_valid_cyc - en_cyc, HALF);

        // Pause right after a pulse
        pause_and_check(13);
        push_expected(13);
        set_enable(1'b1);
        while (exp_q.size() > 6) @(negedge clk);

        // Pause partway through a period
        wait_cycles(3);
        pause_and_check(11);
        set_enable(1'b1);
        drain_queue();
        set_enable(1'b0);
        wait_cycles(2 * HALF + 2);
        check(exp_q.size() == 0, "R8 all samples delivered", exp_q.size(), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 20000; i++) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", exp_q.size(), 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule